// File: doc/BRIEF.md
# Serial EEPROM Byte Reader

This block is a sequencer that fetches a run of bytes from a small serial EEPROM over a four-wire link. The link has an active-low chip select, a serial clock, master data out and master data in. The host places a start byte address, a byte count and a mode flag on the inputs, then pulses `start`.

The block first wakes the device. With chip select held high, it toggles the clock through two full periods. It then serves each byte as a separate transaction: the command code, then (for memory reads) the byte address, then eight clocks that return a byte. Each returned byte appears on `data_out` with a one-cycle `data_valid` strobe. Between transactions the address steps by one and wraps at 8 bits. When the mode flag is set, every transaction reads the device status register instead.

Every clock half-period lasts `HALF_PERIOD` system cycles, and all link timing comes from one counter. A one-cycle `done` pulse marks the end of a request.

Top module: `spi_rom_reader`

## Requirements
- R1: After reset, and whenever `busy` is low, `spi_cs_n` is 1, `spi_sck` is 0, `spi_mosi` is 0 and `busy` is 0.
- R2: Every high phase of `spi_sck` lasts exactly `HALF_PERIOD` system clock cycles.
- R3: An accepted request with a nonzero count begins with a wake-up sequence while `spi_cs_n` is 1. The clock goes high, low, high, low, which is exactly two rising edges before chip select first falls.
- R4: A memory read transaction (`is_status` = 0) keeps `spi_cs_n` low for exactly 24 rising clock edges. The first 8 edges carry the command 0x03, MSB first. The next 8 carry the byte address, MSB first. The last 8 are the data clocks.
- R5: `spi_mosi` changes only while `spi_sck` is low, so the device sees it settled on each rising edge.
- R6: A data bit is sampled at the end of the clock's high phase, and 8 samples are assembled MSB first. At the end of each transaction `data_out` holds the byte and `data_valid` is high for exactly one cycle.
- R7: In status mode (`is_status` = 1), each transaction sends the command 0x05, MSB first, followed by 8 data clocks, which is 16 rising edges in all. It returns the device status byte.
- R8: A request with count N makes exactly N transactions. Between two transactions, chip select is high and the clock and data lines are low for exactly `HALF_PERIOD` cycles. The address of transaction k+1 is the address of transaction k plus one, modulo 256.
- R9: After the last byte, `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R10: A start with count 0 raises `done` in the next cycle. It causes no chip select or clock activity, and `busy` stays low.
- R11: A `start` pulse while `busy` is high is ignored. The running request keeps its own address, count and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| addr | input | 8 | First byte address |
| count | input | 8 | Number of bytes to fetch |
| is_status | input | 1 | 1 = read status register per transaction |
| busy | output | 1 | Request in progress |
| data_out | output | 8 | Last byte fetched |
| data_valid | output | 1 | One-cycle strobe for `data_out` |
| done | output | 1 | One-cycle end-of-request pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Each kind of wrong internal state shows up at the ports within one transaction.

- A wrong bit counter changes the number of rising edges per chip-select window. A device model at the link counts these edges.
- A slipped shift register corrupts the captured command or address, or misaligns the returned byte.
- A wrong half-period counter stretches a clock high phase or the gap between transactions.
- A broken address step or byte count shows up in the addresses that reach the device and in the number of strobes before `done`.

A full sweep over every address makes sure the data path is checked against a computed memory image at every position.

// File: rtl/spi_rom_pkg.sv
// Shared constants and state encoding for the serial EEPROM reader.
// Assumes 8-bit addresses and data, as the supported devices use.
package spi_rom_pkg;
    localparam int BYTE_W      = 8;
    localparam int WAKE_PHASES = 4;
    localparam int FRAME_W     = 2 * BYTE_W;
    localparam int READ_BITS   = 3 * BYTE_W;
    localparam int STAT_BITS   = 2 * BYTE_W;
    localparam int BITCNT_W    = $clog2(READ_BITS);

    localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_STAT = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_GAP
    } seq_state_t;
endpackage

// File: rtl/spi_rom_tick.sv
// Half-period timer: pulses tick once every HALF_PERIOD cycles while run
// is high, starting a fresh period whenever run is low.
// Assumes HALF_PERIOD >= 1.
module spi_rom_tick #(
    parameter int HALF_PERIOD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_PERIOD == 1) begin : g_every
            // Every running cycle ends a phase.
            assign tick = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(HALF_PERIOD);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);
            logic [CNT_W-1:0] cnt;

            // Count cycles within a phase; clear while stopped.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/spi_rom_shift.sv
// Transmit and receive shift registers for one link transaction.
// The transmit register is loaded with command and address and shifts
// MSB first; zeros fill in behind, so the data line idles low once
// the frame is out. The receive register takes one bit per sample.
module spi_rom_shift
    import spi_rom_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    input  logic               sample,
    input  logic               miso,
    output logic               mosi,
    output logic [BYTE_W-1:0]  rx
);
    logic [FRAME_W-1:0] tx;

    // Outgoing frame: load, then move one bit per clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx <= '0;
        end else if (load) begin
            tx <= load_word;
        end else if (shift) begin
            tx <= {tx[FRAME_W-2:0], 1'b0};
        end
    end

    // Incoming bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx <= '0;
        end else if (sample) begin
            rx <= {rx[BYTE_W-2:0], miso};
        end
    end

    assign mosi = tx[FRAME_W-1];
endmodule

// File: rtl/spi_rom_ctrl.sv
// Request sequencer. Accepts a request while idle, runs the wake-up
// clocks with chip select high, then one transaction per byte with a
// one-phase gap between them. Every state change waits for a tick from
// the half-period timer. Assumes miso is already synchronous to clk.
module spi_rom_ctrl
    import spi_rom_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BYTE_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  count,
    input  logic               is_status,
    input  logic               tick,
    output logic               busy,
    output logic               data_valid,
    output logic               done,
    output logic               cs_n,
    output logic               sck,
    output logic               load,
    output logic [FRAME_W-1:0] load_word,
    output logic               shift,
    output logic               sample
);
    localparam logic [1:0] WAKE_LAST = 2'(WAKE_PHASES - 1);
    localparam logic [BITCNT_W-1:0] READ_LAST = BITCNT_W'(READ_BITS - 1);
    localparam logic [BITCNT_W-1:0] STAT_LAST = BITCNT_W'(STAT_BITS - 1);

    seq_state_t          state;
    logic [1:0]          wake_cnt;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   cur_addr;
    logic [BYTE_W-1:0]   remain;
    logic                stat_q;
    logic [BITCNT_W-1:0] last_bit;
    logic [BYTE_W-1:0]   next_addr;
    logic                at_last_bit;

    assign busy        = (state != ST_IDLE);
    assign last_bit    = stat_q ? STAT_LAST : READ_LAST;
    assign at_last_bit = (bit_cnt == last_bit);

    // Shifter controls derived from the current phase.
    always_comb begin
        sample    = tick && (state == ST_BIT_HI);
        shift     = sample && !at_last_bit;
        load      = tick && (((state == ST_WAKE) && (wake_cnt == WAKE_LAST)) ||
                             ((state == ST_GAP) && (remain != 8'd1)));
        next_addr = (state == ST_GAP) ? cur_addr + 1'b1 : cur_addr;
        load_word = stat_q ? {CMD_STAT, {BYTE_W{1'b0}}} : {CMD_READ, next_addr};
    end

    // Phase sequencing and link line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wake_cnt   <= '0;
            bit_cnt    <= '0;
            cur_addr   <= '0;
            remain     <= '0;
            stat_q     <= 1'b0;
            cs_n       <= 1'b1;
            sck        <= 1'b0;
            data_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            done       <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (count == '0) begin
                            done <= 1'b1;
                        end else begin
                            state    <= ST_WAKE;
                            wake_cnt <= '0;
                            cur_addr <= addr;
                            remain   <= count;
                            stat_q   <= is_status;
                            sck      <= 1'b1;
                        end
                    end
                end
                ST_WAKE: begin
                    if (tick) begin
                        if (wake_cnt == WAKE_LAST) begin
                            state   <= ST_BIT_LO;
                            bit_cnt <= '0;
                            cs_n    <= 1'b0;
                            sck     <= 1'b0;
                        end else begin
                            wake_cnt <= wake_cnt + 1'b1;
                            sck      <= ~sck;
                        end
                    end
                end
                ST_BIT_LO: begin
                    if (tick) begin
                        state <= ST_BIT_HI;
                        sck   <= 1'b1;
                    end
                end
                ST_BIT_HI: begin
                    if (tick) begin
                        sck <= 1'b0;
                        if (at_last_bit) begin
                            state      <= ST_GAP;
                            cs_n       <= 1'b1;
                            data_valid <= 1'b1;
                        end else begin
                            state   <= ST_BIT_LO;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (remain == 8'd1) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state    <= ST_BIT_LO;
                            remain   <= remain - 1'b1;
                            cur_addr <= next_addr;
                            bit_cnt  <= '0;
                            cs_n     <= 1'b0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_rom_reader.sv
// Top level of the serial EEPROM reader: timer, sequencer and shifter.
// HALF_PERIOD sets each serial clock half-period in system cycles.
module spi_rom_reader #(
    parameter int HALF_PERIOD = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] addr,
    input  logic [7:0] count,
    input  logic       is_status,
    output logic       busy,
    output logic [7:0] data_out,
    output logic       data_valid,
    output logic       done,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    import spi_rom_pkg::*;

    logic               tick;
    logic               load;
    logic               shift;
    logic               sample;
    logic [FRAME_W-1:0] load_word;

    spi_rom_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spi_rom_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .addr       (addr),
        .count      (count),
        .is_status  (is_status),
        .tick       (tick),
        .busy       (busy),
        .data_valid (data_valid),
        .done       (done),
        .cs_n       (spi_cs_n),
        .sck        (spi_sck),
        .load       (load),
        .load_word  (load_word),
        .shift      (shift),
        .sample     (sample)
    );

    spi_rom_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .shift     (shift),
        .sample    (sample),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx        (data_out)
    );
endmodule

// File: rtl/spi_rom_reader_chk.sv
// Protocol checker for spi_rom_reader, attached by bind. Observes ports
// only; counts high-phase length itself so no deep history is needed.
module spi_rom_reader_chk #(
    parameter int HALF_PERIOD = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] count,
    input logic       busy,
    input logic       done,
    input logic       data_valid,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi
);
    logic [15:0] hi_cnt;

    // Length of the current run of high clock samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (spi_sck) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sck && !spi_mosi));

    a_r2_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> (hi_cnt == 16'(HALF_PERIOD)));

    a_r5_mosi_low_clk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> !spi_sck);

    a_r6_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (busy && spi_cs_n && !spi_sck));

    a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(start && count == 8'd0)) |=> !done);

    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == 8'd0) |=> (done && !busy));
endmodule

bind spi_rom_reader spi_rom_reader_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .count      (count),
    .busy       (busy),
    .done       (done),
    .data_valid (data_valid),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi)
);

// File: tb/test_spi_rom_reader.sv
// Bench: device model on the link, request tasks, computed expectations.
module test_spi_rom_reader;
    localparam int HP = 3;
    localparam logic [7:0] STAT_BYTE = 8'hA6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] count = '0;
    logic       is_status = 1'b0;
    logic       busy, data_valid, done;
    logic [7:0] data_out;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_rom_reader #(.HALF_PERIOD(HP)) i_spi_rom_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .count(count),
        .is_status(is_status), .busy(busy), .data_out(data_out),
        .data_valid(data_valid), .done(done), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return 8'((int'(a) * 37 + 11) & 255);
    endfunction

    // ---------------- device model ----------------
    int         rise_cnt = 0;
    logic [7:0] in_sr = '0;
    logic [7:0] m_op = '0;
    logic [7:0] m_addr = '0;
    bit         in_tx = 0;
    int         tx_n = 0;
    int         wake_rises = 0;
    logic [7:0] tx_op [256];
    logic [7:0] tx_addr [256];
    int         tx_rises [256];

    always @(negedge spi_cs_n) begin
        in_tx = 1;
        rise_cnt = 0;
    end

    always @(posedge spi_cs_n) begin
        if (in_tx) begin
            if (tx_n < 256) begin
                tx_op[tx_n] = m_op;
                tx_addr[tx_n] = m_addr;
                tx_rises[tx_n] = rise_cnt;
            end
            tx_n++;
            in_tx = 0;
        end
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n) begin
            wake_rises++;
        end else begin
            in_sr = {in_sr[6:0], spi_mosi};
            rise_cnt++;
            if (rise_cnt == 8) m_op = in_sr;
            if (rise_cnt == 16) m_addr = in_sr;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (m_op == 8'h05 && rise_cnt >= 8 && rise_cnt < 16)
                spi_miso <= STAT_BYTE[15 - rise_cnt];
            else if (m_op == 8'h03 && rise_cnt >= 16 && rise_cnt < 24)
                spi_miso <= mem_val(m_addr)[23 - rise_cnt];
        end
    end

    // ---------------- port monitor ----------------
    logic [7:0] got [256];
    int got_n = 0, done_n = 0;
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    int cs_run = 0, gap_min = 1000, gap_max = 0;
    bit seen_tx = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_valid) begin
                if (got_n < 256) got[got_n] = data_out;
                got_n++;
            end
            if (done) done_n++;
            if (spi_sck) hi_run++;
            else begin
                if (hi_run > 0) begin
                    if (hi_run < hi_min) hi_min = hi_run;
                    if (hi_run > hi_max) hi_max = hi_run;
                end
                hi_run = 0;
            end
            if (spi_cs_n) cs_run++;
            else begin
                if (seen_tx && cs_run > 0) begin
                    if (cs_run < gap_min) gap_min = cs_run;
                    if (cs_run > gap_max) gap_max = cs_run;
                end
                cs_run = 0;
                seen_tx = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic clear_stats();
        got_n = 0; done_n = 0; tx_n = 0; wake_rises = 0;
        hi_run = 0; hi_min = 1000; hi_max = 0;
        cs_run = 0; gap_min = 1000; gap_max = 0; seen_tx = 0;
    endtask

    task automatic check_idle(input string tag);
        check(spi_cs_n === 1'b1, {tag, " cs_n idle"}, int'(spi_cs_n), 1);
        check(spi_sck === 1'b0, {tag, " sck idle"}, int'(spi_sck), 0);
        check(spi_mosi === 1'b0, {tag, " mosi idle"}, int'(spi_mosi), 0);
        check(busy === 1'b0, {tag, " busy idle"}, int'(busy), 0);
    endtask

    // Run one request; if poke, pulse start with other values mid-run (R11).
    task automatic run_req(input logic [7:0] a, input logic [7:0] c, input bit st, input bit poke);
        int cyc = 0;
        clear_stats();
        @(negedge clk);
        addr = a; count = c; is_status = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            cyc++;
            if (poke && cyc == 100) begin
                addr = 8'h55; count = 8'd9; is_status = ~st; start = 1'b1;
            end
            if (poke && cyc == 101) start = 1'b0;
            @(negedge clk);
        end
        check(busy === 1'b0, "R9 busy low with done", int'(busy), 0);
        check_idle("R1 after request");
        repeat (3) @(negedge clk);
        check(done_n == 1, "R9 single done pulse", done_n, 1);
        check(got_n == int'(c), "R11/R6 strobe count", got_n, int'(c));
        check(tx_n == int'(c), "R8 transaction count", tx_n, int'(c));
        check(wake_rises == 2, "R3 wake rising edges", wake_rises, 2);
        check(hi_min == HP && hi_max == HP, "R2 high phase width", hi_max, HP);
        if (c > 1) check(gap_min == HP && gap_max == HP, "R8 gap width", gap_max, HP);
        for (int i = 0; i < int'(c) && i < 256 && i < got_n && i < tx_n; i++) begin
            logic [7:0] ea;
            ea = a + 8'(i);
            if (st) begin
                check(got[i] == STAT_BYTE, "R7 status byte", int'(got[i]), int'(STAT_BYTE));
                check(tx_op[i] == 8'h05, "R7 status command", int'(tx_op[i]), 5);
                check(tx_rises[i] == 16, "R7 status clocks", tx_rises[i], 16);
            end else begin
                check(got[i] == mem_val(ea), "R6 read data", int'(got[i]), int'(mem_val(ea)));
                check(tx_op[i] == 8'h03, "R4 read command", int'(tx_op[i]), 3);
                check(tx_addr[i] == ea, "R4/R8 address", int'(tx_addr[i]), int'(ea));
                check(tx_rises[i] == 24, "R4 read clocks", tx_rises[i], 24);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_idle("R1 reset");
        check(done === 1'b0 && data_valid === 1'b0, "R1 reset strobes", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_req(8'h00, 8'd1, 1'b0, 1'b0);    // single read
        run_req(8'hFE, 8'd4, 1'b0, 1'b0);    // R8 wrap through 0xFF
        run_req(8'h20, 8'd3, 1'b1, 1'b0);    // R7 status mode

        // R10: zero count
        clear_stats();
        @(negedge clk);
        addr = 8'h40; count = 8'd0; is_status = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R10 done next cycle", int'(done), 1);
        check(busy === 1'b0, "R10 busy stays low", int'(busy), 0);
        repeat (4 * HP) @(negedge clk);
        check(tx_n == 0 && wake_rises == 0, "R10 no link activity", tx_n + wake_rises, 0);
        check(done_n == 1, "R10 single done", done_n, 1);

        run_req(8'h80, 8'd5, 1'b0, 1'b1);    // R11 start ignored while busy
        run_req(8'h01, 8'd255, 1'b0, 1'b0);  // sweep of all other addresses

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule